// File: doc/BRIEF.md
# Cache-Line Block Copy Engine

This engine moves a run of whole cache lines from one memory region to another, or fills a destination region with zeros, without the processor touching the data. Software sets up three line-aligned addresses (source, destination, notification) over a small register bus. It then writes one control word that carries a start flag, the mode bits and a line count. From that point the engine works alone. It reads each source line through a single-outstanding memory master port and writes the line back out at the destination.

When the run ends, the engine can store its final status word at the notification address. A poller can then learn from one memory read that the run finished and whether it failed. The first error response stops the run. The engine records the failure class in a six-bit cause field. A separate class marks a response that never arrived, so software can tell a timeout apart from the retryable faults.

The memory master uses valid/ready handshakes. A request stays valid, with all its fields unchanged, until the memory accepts it. The next request is raised only after the response to the current one has been taken. The engine never applies back-pressure on responses: it holds the response ready high at all times and drops any response that arrives while it is not waiting for one. The register bus has no handshake. A write takes effect at the clock edge on which it is presented, and read data follows the read address combinationally.

Top module: `line_copy_engine`

## Requirements
- R1: After reset the status word (register 0) reads zero, the address registers read zero and no memory request is valid.
- R2: While the engine is idle, a write to register 0 with bit 20 set starts a run. Bits 15:0 hold the line count, bit 24 selects zero-fill and bit 28 selects notification. While the run is in progress, bit 20 of the status reads 1 and bits 15:0 show the lines not yet completed.
- R3: In copy mode, line i is read at source plus i line sizes. It is then written at destination plus i line sizes with the data just read. The read response for a line is taken before that line's write is raised, and the requests strictly alternate read, write.
- R4: In zero-fill mode no read is issued. Every destination line is written with all-zero data.
- R5: A memory request that is not yet accepted keeps valid high with stable address, direction and data. At most one request is outstanding.
- R6: Address registers 1 (source), 2 (destination) and 3 (notification) ignore the low log2(line size) bits. They read back with those bits zero, and all memory requests are line-aligned.
- R7: A line count of zero finishes at once with no data traffic. If notification is on, only the notification write is made.
- R8: A write to register 0 while a run or its notification is in progress has no effect. The run continues with its original count and modes.
- R9: With notification on, the last request of a run is a write to the notification address. Its low 64 data bits equal the final status word with bit 20 clear, and all upper data bits are zero.
- R10: On the first response with a non-zero error vector, the engine issues no further line requests. It copies the vector into status bits 41:36, sets error bit 21 and clears busy. Bits 15:0 then show the lines not completed. The notification write still follows when notification is on.
- R11: If no response comes within TIMEOUT_CYCLES cycles of waiting, the run fails as in R10 with cause 6'b010000 (status bit 40) only.
- R12: A write to register 0 with bit 20 clear while idle clears the whole status word to zero without starting a run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 control/status, 1 source, 2 destination, 3 notification |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Read data of the register selected by reg_addr |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 for a write request, 0 for a read |
| mem_req_addr | output | ADDR_W | Line-aligned byte address |
| mem_req_data | output | LINE_BYTES*8 | Write data for a line |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_ready | output | 1 | Response ready, held high |
| mem_rsp_data | input | LINE_BYTES*8 | Read data of a line |
| mem_rsp_err | input | 6 | Error vector: bit 0 short, 1 long, 2 data-path, 3 access, 5 retry limit |

## Verification
The bench builds the engine with a 16-bit address, 8-byte lines and a 16-cycle response timeout. The 64-bit line then matches the status word width. A bench memory model can compute every read line from its address, and a timed-out run finishes in a few dozen cycles. It sweeps every combination of count 0 to 4 with both mode bits, on unaligned programmed addresses, under varying accept and response delays. It also places an error response on each request position of a copy and covers a silent memory.

// File: rtl/lce_pkg.sv
package lce_pkg;

  localparam int CNT_W        = 16;
  localparam int CAUSE_W      = 6;
  localparam int ST_BUSY_BIT  = 20;
  localparam int ST_ERR_BIT   = 21;
  localparam int ST_ZF_BIT    = 24;
  localparam int ST_NT_BIT    = 28;
  localparam int ST_CAUSE_LSB = 36;
  localparam int CAUSE_TIMEOUT_IDX = 4;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_SRC  = 2'd1;
  localparam logic [1:0] RA_DST  = 2'd2;
  localparam logic [1:0] RA_NTF  = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_REQ,
    S_RD_WAIT,
    S_WR_REQ,
    S_WR_WAIT,
    S_NT_REQ,
    S_NT_WAIT
  } seq_state_e;

  function automatic logic [63:0] pack_status(
    input logic               busy,
    input logic               err,
    input logic               zf,
    input logic               nt,
    input logic [CAUSE_W-1:0] cause,
    input logic [CNT_W-1:0]   cnt
  );
    logic [63:0] w;
    w = '0;
    w[CNT_W-1:0]                          = cnt;
    w[ST_BUSY_BIT]                        = busy;
    w[ST_ERR_BIT]                         = err;
    w[ST_ZF_BIT]                          = zf;
    w[ST_NT_BIT]                          = nt;
    w[ST_CAUSE_LSB +: CAUSE_W]            = cause;
    return w;
  endfunction

endpackage

// File: rtl/lce_regs.sv
module lce_regs
  import lce_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int OFF    = 6,
  parameter int LIDX_W = ADDR_W - OFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  input  logic [63:0]       status_word,
  output logic              ctrl_wr,
  output logic              ctrl_go,
  output logic              ctrl_zf,
  output logic              ctrl_nt,
  output logic [CNT_W-1:0]  ctrl_cnt,
  output logic [LIDX_W-1:0] src_line,
  output logic [LIDX_W-1:0] dst_line,
  output logic [LIDX_W-1:0] ntf_line
);

  logic [LIDX_W-1:0] line_q [3];
  logic [LIDX_W-1:0] wline;
  logic              unused_wbits;

  assign wline = reg_wdata[ADDR_W-1:OFF];
  assign unused_wbits = ^{reg_wdata[63:ADDR_W], reg_wdata[OFF-1:0]};

  generate
    for (genvar g = 0; g < 3; g++) begin : g_addr_reg
      localparam logic [1:0] MY_IDX = 2'(g + 1);
      always_ff @(posedge clk) begin
        if (!rst_n)
          line_q[g] <= '0;
        else if (reg_wr && reg_addr == MY_IDX)
          line_q[g] <= wline;
      end
    end
  endgenerate

  assign src_line = line_q[0];
  assign dst_line = line_q[1];
  assign ntf_line = line_q[2];

  assign ctrl_wr  = reg_wr && reg_addr == RA_CTRL;
  assign ctrl_go  = reg_wdata[ST_BUSY_BIT];
  assign ctrl_zf  = reg_wdata[ST_ZF_BIT];
  assign ctrl_nt  = reg_wdata[ST_NT_BIT];
  assign ctrl_cnt = reg_wdata[CNT_W-1:0];

  always_comb begin
    unique case (reg_addr)
      RA_CTRL: reg_rdata = status_word;
      RA_SRC:  reg_rdata = 64'({line_q[0], {OFF{1'b0}}});
      RA_DST:  reg_rdata = 64'({line_q[1], {OFF{1'b0}}});
      default: reg_rdata = 64'({line_q[2], {OFF{1'b0}}});
    endcase
  end

endmodule

// File: rtl/lce_timer.sv
module lce_timer #(
  parameter int TIMEOUT_CYCLES = 1024,
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run)
      cnt_q <= '0;
    else if (!expired)
      cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && cnt_q == TW'(TIMEOUT_CYCLES - 1);

  a_r11_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TW'(TIMEOUT_CYCLES - 1));

endmodule

// File: rtl/lce_seq.sv
module lce_seq
  import lce_pkg::*;
#(
  parameter int ADDR_W    = 48,
  parameter int OFF       = 6,
  parameter int LINE_BITS = 512,
  parameter int LIDX_W    = ADDR_W - OFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctrl_wr,
  input  logic               ctrl_go,
  input  logic               ctrl_zf,
  input  logic               ctrl_nt,
  input  logic [CNT_W-1:0]   ctrl_cnt,
  input  logic [LIDX_W-1:0]  src_line,
  input  logic [LIDX_W-1:0]  dst_line,
  input  logic [LIDX_W-1:0]  ntf_line,
  input  logic               tmo,
  output logic               wait_run,
  output logic [63:0]        status_word,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [LINE_BITS-1:0] mem_req_data,
  input  logic               mem_rsp_valid,
  input  logic [LINE_BITS-1:0] mem_rsp_data,
  input  logic [CAUSE_W-1:0] mem_rsp_err
);

  seq_state_e           state_q;
  logic                 zf_q, nt_q, err_q;
  logic [CAUSE_W-1:0]   cause_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [LIDX_W-1:0]    src_q, dst_q, ntf_q;
  logic [LINE_BITS-1:0] buf_q;
  logic                 line_held_q;
  logic                 idle, start, clear, rsp_bad, req_fire;
  logic [LIDX_W-1:0]    ptr;
  logic [CAUSE_W-1:0]   tmo_cause;

  assign idle      = state_q == S_IDLE;
  assign start     = ctrl_wr && idle && ctrl_go;
  assign clear     = ctrl_wr && idle && !ctrl_go;
  assign rsp_bad   = |mem_rsp_err;
  assign req_fire  = mem_req_valid && mem_req_ready;
  assign wait_run  = state_q inside {S_RD_WAIT, S_WR_WAIT, S_NT_WAIT};
  assign tmo_cause = CAUSE_W'(1) << CAUSE_TIMEOUT_IDX;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= S_IDLE;
      zf_q        <= 1'b0;
      nt_q        <= 1'b0;
      err_q       <= 1'b0;
      cause_q     <= '0;
      cnt_q       <= '0;
      src_q       <= '0;
      dst_q       <= '0;
      ntf_q       <= '0;
      buf_q       <= '0;
      line_held_q <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (start) begin
            zf_q    <= ctrl_zf;
            nt_q    <= ctrl_nt;
            cnt_q   <= ctrl_cnt;
            err_q   <= 1'b0;
            cause_q <= '0;
            src_q   <= src_line;
            dst_q   <= dst_line;
            ntf_q   <= ntf_line;
            if (ctrl_cnt == '0)
              state_q <= ctrl_nt ? S_NT_REQ : S_IDLE;
            else
              state_q <= ctrl_zf ? S_WR_REQ : S_RD_REQ;
          end else if (clear) begin
            zf_q    <= 1'b0;
            nt_q    <= 1'b0;
            cnt_q   <= '0;
            err_q   <= 1'b0;
            cause_q <= '0;
          end
        end
        S_RD_REQ: if (mem_req_ready) state_q <= S_RD_WAIT;
        S_RD_WAIT: begin
          if (mem_rsp_valid) begin
            if (rsp_bad) begin
              err_q   <= 1'b1;
              cause_q <= mem_rsp_err;
              state_q <= nt_q ? S_NT_REQ : S_IDLE;
            end else begin
              buf_q       <= mem_rsp_data;
              line_held_q <= 1'b1;
              state_q     <= S_WR_REQ;
            end
          end else if (tmo) begin
            err_q   <= 1'b1;
            cause_q <= tmo_cause;
            state_q <= nt_q ? S_NT_REQ : S_IDLE;
          end
        end
        S_WR_REQ: begin
          if (mem_req_ready) begin
            line_held_q <= 1'b0;
            state_q     <= S_WR_WAIT;
          end
        end
        S_WR_WAIT: begin
          if (mem_rsp_valid) begin
            if (rsp_bad) begin
              err_q   <= 1'b1;
              cause_q <= mem_rsp_err;
              state_q <= nt_q ? S_NT_REQ : S_IDLE;
            end else begin
              cnt_q <= cnt_q - 1'b1;
              src_q <= src_q + 1'b1;
              dst_q <= dst_q + 1'b1;
              if (cnt_q == CNT_W'(1))
                state_q <= nt_q ? S_NT_REQ : S_IDLE;
              else
                state_q <= zf_q ? S_WR_REQ : S_RD_REQ;
            end
          end else if (tmo) begin
            err_q   <= 1'b1;
            cause_q <= tmo_cause;
            state_q <= nt_q ? S_NT_REQ : S_IDLE;
          end
        end
        S_NT_REQ: if (mem_req_ready) state_q <= S_NT_WAIT;
        S_NT_WAIT: begin
          if (mem_rsp_valid) begin
            if (rsp_bad && !err_q) begin
              err_q   <= 1'b1;
              cause_q <= mem_rsp_err;
            end
            state_q <= S_IDLE;
          end else if (tmo) begin
            if (!err_q) begin
              err_q   <= 1'b1;
              cause_q <= tmo_cause;
            end
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      S_RD_REQ: ptr = src_q;
      S_NT_REQ: ptr = ntf_q;
      default:  ptr = dst_q;
    endcase
  end

  assign mem_req_valid = state_q inside {S_RD_REQ, S_WR_REQ, S_NT_REQ};
  assign mem_req_write = state_q != S_RD_REQ;
  assign mem_req_addr  = {ptr, {OFF{1'b0}}};

  always_comb begin
    if (state_q == S_NT_REQ)
      mem_req_data = LINE_BITS'(pack_status(1'b0, err_q, zf_q, nt_q, cause_q, cnt_q));
    else if (state_q == S_WR_REQ && !zf_q)
      mem_req_data = buf_q;
    else
      mem_req_data = '0;
  end

  assign status_word = pack_status(!idle, err_q, zf_q, nt_q, cause_q, cnt_q);

  // Requests hold still until accepted
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_data));

  // One outstanding: no request while a response is awaited
  a_r5_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !mem_req_valid);

  // Zero-fill never reads
  a_r4_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && zf_q |-> mem_req_write);

  // A copy write only goes out with its line already read
  a_r3_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_WR_REQ && !zf_q |-> line_held_q);

  // After a failure only the notification may follow
  a_r10_halt: assert property (@(posedge clk) disable iff (!rst_n)
    err_q && mem_req_valid |-> state_q == S_NT_REQ);

  // Control writes during a run leave its modes alone
  a_r8_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !idle |=> $stable(zf_q) && $stable(nt_q));

  // Zero count without notification finishes at once
  a_r7_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
    start && ctrl_cnt == '0 && !ctrl_nt |=> idle && !mem_req_valid);

endmodule

// File: rtl/line_copy_engine.sv
module line_copy_engine
  import lce_pkg::*;
#(
  parameter int ADDR_W         = 48,
  parameter int LINE_BYTES     = 64,
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [1:0]              reg_addr,
  input  logic [63:0]             reg_wdata,
  output logic [63:0]             reg_rdata,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic                    mem_req_write,
  output logic [ADDR_W-1:0]       mem_req_addr,
  output logic [LINE_BYTES*8-1:0] mem_req_data,
  input  logic                    mem_rsp_valid,
  output logic                    mem_rsp_ready,
  input  logic [LINE_BYTES*8-1:0] mem_rsp_data,
  input  logic [5:0]              mem_rsp_err
);

  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam int OFF       = $clog2(LINE_BYTES);
  localparam int LIDX_W    = ADDR_W - OFF;

  logic              ctrl_wr, ctrl_go, ctrl_zf, ctrl_nt;
  logic [CNT_W-1:0]  ctrl_cnt;
  logic [LIDX_W-1:0] src_line, dst_line, ntf_line;
  logic [63:0]       status_word;
  logic              wait_run, tmo;

  assign mem_rsp_ready = 1'b1;

  lce_regs #(.ADDR_W(ADDR_W), .OFF(OFF), .LIDX_W(LIDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .status_word(status_word),
    .ctrl_wr(ctrl_wr), .ctrl_go(ctrl_go), .ctrl_zf(ctrl_zf), .ctrl_nt(ctrl_nt),
    .ctrl_cnt(ctrl_cnt),
    .src_line(src_line), .dst_line(dst_line), .ntf_line(ntf_line)
  );

  lce_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(wait_run), .expired(tmo)
  );

  lce_seq #(.ADDR_W(ADDR_W), .OFF(OFF), .LINE_BITS(LINE_BITS), .LIDX_W(LIDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .ctrl_go(ctrl_go), .ctrl_zf(ctrl_zf), .ctrl_nt(ctrl_nt),
    .ctrl_cnt(ctrl_cnt),
    .src_line(src_line), .dst_line(dst_line), .ntf_line(ntf_line),
    .tmo(tmo), .wait_run(wait_run), .status_word(status_word),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_data(mem_req_data),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
  );

  // Requests are always line-aligned
  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[OFF-1:0] == '0);

  // Reset leaves the memory port quiet
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !mem_req_valid);

endmodule

// File: tb/test_line_copy_engine.sv
module test_line_copy_engine;

  localparam int CLK_PERIOD = 10;
  localparam int AW  = 16;
  localparam int LB  = 8;
  localparam int TMO = 16;
  localparam int LBITS = LB * 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic mem_req_valid, mem_req_ready = 1'b0, mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [LBITS-1:0] mem_req_data;
  logic mem_rsp_valid = 1'b0, mem_rsp_ready;
  logic [LBITS-1:0] mem_rsp_data = '0;
  logic [5:0] mem_rsp_err = '0;

  line_copy_engine #(.ADDR_W(AW), .LINE_BYTES(LB), .TIMEOUT_CYCLES(TMO)) i_line_copy_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int nreq = 0, err_idx = -1, drop_idx = -1;
  logic [5:0] err_code = '0;
  logic        log_wr   [64];
  logic [15:0] log_addr [64];
  logic [63:0] log_data [64];
  bit done = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [15:0] a);
    return {a, ~a, a ^ 16'h5A5A, a + 16'h1234};
  endfunction

  function automatic logic [63:0] stw(input bit err, input bit zf, input bit nt,
                                      input logic [5:0] cause, input logic [15:0] cnt);
    return 64'(cnt) | (64'(err) << 21) | (64'(zf) << 24) | (64'(nt) << 28) | (64'(cause) << 36);
  endfunction

  // Memory model: stalls accept, delays response, injects faults
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        int idx;
        idx = nreq;
        repeat (idx % 3) @(negedge clk);
        mem_req_ready = 1'b1;
        if (idx < 64) begin
          log_wr[idx] = mem_req_write; log_addr[idx] = mem_req_addr; log_data[idx] = mem_req_data;
        end
        nreq++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (idx != drop_idx) begin
          repeat (idx % 2) @(negedge clk);
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = log_wr[idx] ? '0 : pat(log_addr[idx]);
          mem_rsp_err   = (idx == err_idx) ? err_code : 6'd0;
          @(negedge clk);
          mem_rsp_valid = 1'b0;
          mem_rsp_err   = '0;
        end
      end
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [63:0] s;
    for (int i = 0; i < 400; i++) begin
      rd_reg(2'd0, s);
      if (!s[20]) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input logic [15:0] src, input logic [15:0] dst, input logic [15:0] ntf,
                     input int cnt, input bit zf, input bit nt, input int ndata,
                     input int left, input bit err, input logic [5:0] cause);
    logic [63:0] s, exp;
    logic [15:0] sa, da, na;
    string rq;
    rq = (cnt == 0) ? "R7" : (zf ? "R4" : "R3");
    sa = src & 16'hFFF8; da = dst & 16'hFFF8; na = ntf & 16'hFFF8;
    nreq = 0;
    wr_reg(2'd1, 64'(src)); wr_reg(2'd2, 64'(dst)); wr_reg(2'd3, 64'(ntf));
    wr_reg(2'd0, (64'd1 << 20) | (64'(zf) << 24) | (64'(nt) << 28) | 64'(cnt));
    wait_idle();
    exp = stw(err, zf, nt, cause, 16'(left));
    rd_reg(2'd0, s);
    chk(err ? "R10 final status" : "R2 final status", s, exp);
    chk({rq, " request count"}, 64'(nreq), 64'(ndata + int'(nt)));
    for (int j = 0; j < ndata && j < nreq; j++) begin
      int line;
      bit rd;
      line = zf ? j : j / 2;
      rd = !zf && (j % 2 == 0);
      chk({rq, " direction"}, 64'(log_wr[j]), 64'(!rd));
      chk({"R6 ", rq, " address"}, 64'(log_addr[j]), 64'(rd ? sa + 16'(line * LB) : da + 16'(line * LB)));
      if (!rd) chk({rq, " write data"}, log_data[j], zf ? 64'd0 : pat(sa + 16'(line * LB)));
    end
    if (nt && nreq > ndata) begin
      chk("R9 notify address", 64'(log_addr[ndata]), 64'(na));
      chk("R9 notify word", log_data[ndata], exp);
      chk("R9 notify is write", 64'(log_wr[ndata]), 64'd1);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      report();
    end
  end

  initial begin
    logic [63:0] s;
    logic [5:0] codes [5];
    codes[0] = 6'h01; codes[1] = 6'h02; codes[2] = 6'h04; codes[3] = 6'h08; codes[4] = 6'h20;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(2'd0, s); chk("R1 status after reset", s, 64'd0);
    chk("R1 no request after reset", 64'(mem_req_valid), 64'd0);
    rd_reg(2'd3, s); chk("R1 notify reg after reset", s, 64'd0);

    // R6 low bits dropped on readback
    wr_reg(2'd1, 64'h0000_0000_0000_1237);
    rd_reg(2'd1, s); chk("R6 source readback", s, 64'h1230);
    wr_reg(2'd2, 64'hFFFF_0000_0000_ABCF);
    rd_reg(2'd2, s); chk("R6 destination readback", s, 64'hABC8);

    // Sweep of counts and modes (R2, R3, R4, R7, R9)
    for (int cnt = 0; cnt < 5; cnt++) begin
      for (int m = 0; m < 4; m++) begin
        run(16'h0100 + 16'(cnt * 64) + 16'd3, 16'h2000 + 16'(m * 256) + 16'(cnt * 8) + 16'd5,
            16'h3F09, cnt, m[0], m[1], cnt * (m[0] ? 1 : 2), 0, 1'b0, 6'd0);
      end
    end

    // R10 error response on every request of a 3-line copy
    for (int j = 0; j < 6; j++) begin
      err_idx = j; err_code = codes[j % 5];
      run(16'h0400, 16'h0800, 16'h0C00, 3, 1'b0, 1'b1, j + 1, 3 - j / 2, 1'b1, codes[j % 5]);
    end
    err_idx = 1; err_code = 6'h08;
    run(16'h0400, 16'h0900, 16'h0C00, 3, 1'b1, 1'b0, 2, 2, 1'b1, 6'h08);
    err_idx = -1;

    // R11 silent memory on the first write
    drop_idx = 1;
    run(16'h0500, 16'h0A00, 16'h0C40, 2, 1'b0, 1'b1, 2, 2, 1'b1, 6'h10);
    drop_idx = -1;

    // R12 clear from idle
    wr_reg(2'd0, 64'h0);
    rd_reg(2'd0, s); chk("R12 status cleared", s, 64'd0);

    // R8 control write during a run
    nreq = 0;
    wr_reg(2'd1, 64'h0600); wr_reg(2'd2, 64'h0E00);
    wr_reg(2'd0, (64'd1 << 20) | 64'd4);
    wr_reg(2'd0, (64'd1 << 20) | (64'd1 << 24) | (64'd1 << 28) | 64'd1);
    rd_reg(2'd0, s);
    chk("R8 modes unchanged", 64'({s[28], s[24]}), 64'd0);
    chk("R2 busy while running", 64'(s[20]), 64'd1);
    chk("R2 count in progress", 64'(s[15:0] != 0 && s[15:0] <= 4), 64'd1);
    wait_idle();
    chk("R8 original count served", 64'(nreq), 64'd8);
    rd_reg(2'd0, s); chk("R8 final status", s, 64'd0);
    for (int j = 0; j < 8; j++)
      if (j % 2 == 1) chk("R8 R3 data", log_data[j], pat(16'h0600 + 16'((j / 2) * LB)));

    done = 1;
    report();
  end

endmodule